// File: doc/BRIEF.md
# Read-Modify-Write Bus Sequencer

This block runs the bus side of a single-operand instruction that reads an operand, lets an external ALU transform it and writes the result back. A one-cycle `start` supplies an addressing mode, a register selector, an operand size, the current address-register value, a precomputed effective address and the program counter. The block then issues a mode- and size-dependent series of prefetch, read, write and idle cycles on a 16-bit word bus that uses request and acknowledge. Between the last read and the write-back prefetch it pulses `exec_strobe`, and it captures `alu_result` in that cycle.

Operands of 32 bits take two bus words. The upper half is read first and written last. Post-increment and pre-decrement modes report the updated address register through `areg_wr`/`areg_out`. A register-direct data destination needs no memory access. Combinations the block does not support end at once with an `err` pulse.

Top module: `rmw_seq`

## Requirements
- R1: Mode 0 (data register) gives `exec_strobe` with `operand` equal to zero, then one prefetch cycle, then `done`. No read or write cycle is issued. Bus kind codes: 0 prefetch, 1 read, 2 write, 3 idle.
- R2: For size 0 (byte) or size 1 (word) memory operands, the block issues one read at the operand address and sets `operand` = {16'h0, read word}. It then pulses `exec_strobe`, issues a prefetch, and writes `alu_result[15:0]` to the same address.
- R3: For size 2 (long), the block reads the operand address and then the operand address + 2. `operand` = {first word, second word} when `exec_strobe` pulses.
- R4: For long, after the prefetch the block writes `alu_result[15:0]` at the operand address + 2 and then `alu_result[31:16]` at the operand address.
- R5: Mode 3 (post-increment) uses the address register as the operand address. It pulses `areg_wr` with `areg_out` = register + 1/2/4 (byte/word/long) in the same cycle as `done`.
- R6: Mode 4 (pre-decrement) pulses `areg_wr` with register − 1/2/4 one cycle after `start`, before any bus cycle. That value is the operand address. The long form issues one idle bus cycle (address 0) before the first read. Mode 2 uses the register unchanged.
- R7: Modes 5 and 6, and mode 7 with selector 0, read at `ea_in` after exactly one prefetch.
- R8: Mode 7 with selector 1 issues two prefetches before the read.
- R9: Each bus cycle holds its request, kind, address and write data until `bus_ack`. The sequence advances one step per acknowledged cycle.
- R10: `done` is a one-cycle pulse in the cycle after the last bus cycle is acknowledged. After reset the block is idle with no request and no pulses.
- R11: Mode 1, mode 7 with selector 2–7, or size 3 give an `err` pulse one cycle after `start` and no bus cycle.
- R12: `start` is ignored while a sequence is running.
- R13: Prefetch cycles address `pc_in`, then `pc_in`+2 and so on, advancing by 2 per acknowledged prefetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a sequence (sampled while idle) |
| ea_mode | input | 3 | Addressing mode |
| ea_reg | input | 3 | Register / mode-7 selector |
| op_size | input | 2 | 0 byte, 1 word, 2 long |
| areg_in | input | ADDR_W | Address register value |
| ea_in | input | ADDR_W | Precomputed effective address |
| pc_in | input | ADDR_W | Address of next prefetch |
| bus_req | output | 1 | Bus cycle request |
| bus_kind | output | 2 | Cycle kind |
| bus_addr | output | ADDR_W | Cycle address |
| bus_wdata | output | WORD_W | Write data |
| bus_ack | input | 1 | Cycle acknowledge |
| bus_rdata | input | WORD_W | Read data |
| exec_strobe | output | 1 | ALU execute pulse |
| operand | output | 2*WORD_W | Operand to ALU |
| alu_result | input | 2*WORD_W | ALU result |
| areg_wr | output | 1 | Address register update |
| areg_out | output | ADDR_W | Updated address register |
| done | output | 1 | Sequence complete |
| err | output | 1 | Unsupported combination |

## Verification
With immediate acknowledge, each bus cycle takes one cycle. `err` and the pre-decrement `areg_wr` are due one cycle after `start`. `done` is due one cycle after the final acknowledge. The bench counts rising edges and stamps every observed event at the falling edge after it, so these offsets are checked exactly. Stalled runs inject wait cycles and must produce the same event list, which shows that nothing advances without acknowledge.

// File: rtl/rmw_seq_pkg.sv
package rmw_seq_pkg;
  typedef enum logic [1:0] {BK_FETCH = 2'd0, BK_READ = 2'd1, BK_WRITE = 2'd2, BK_IDLE = 2'd3} bus_kind_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_SETUP, ST_GAP, ST_PRE, ST_RD, ST_EXEC, ST_PF, ST_WR, ST_FIN, ST_ERR
  } seq_st_e;

  typedef struct packed {
    logic       valid;
    logic       is_dreg;
    logic       use_areg;
    logic       predec;
    logic       postinc;
    logic       is_long;
    logic [1:0] npre;
    logic [2:0] step;
  } plan_t;

  // byte/word/long address stride
  function automatic logic [2:0] size_step(input logic [1:0] sz);
    case (sz)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/rmw_mode_decode.sv
module rmw_mode_decode import rmw_seq_pkg::*; (
  input  logic [2:0] ea_mode,
  input  logic [2:0] ea_reg,
  input  logic [1:0] op_size,
  output plan_t      plan
);
  always_comb begin
    plan         = '0;
    plan.is_long = (op_size == 2'd2);
    plan.step    = size_step(op_size);
    case (ea_mode)
      3'd0: begin plan.valid = 1'b1; plan.is_dreg = 1'b1; end
      3'd2: begin plan.valid = 1'b1; plan.use_areg = 1'b1; end
      3'd3: begin plan.valid = 1'b1; plan.use_areg = 1'b1; plan.postinc = 1'b1; end
      3'd4: begin plan.valid = 1'b1; plan.use_areg = 1'b1; plan.predec = 1'b1; end
      3'd5, 3'd6: begin plan.valid = 1'b1; plan.npre = 2'd1; end
      3'd7: begin
        if (ea_reg == 3'd0) begin plan.valid = 1'b1; plan.npre = 2'd1; end
        else if (ea_reg == 3'd1) begin plan.valid = 1'b1; plan.npre = 2'd2; end
      end
      default: plan.valid = 1'b0;
    endcase
    if (op_size == 2'd3) plan.valid = 1'b0;
  end
endmodule

// File: rtl/rmw_bus_map.sv
module rmw_bus_map import rmw_seq_pkg::*; #(
  parameter int ADDR_W = 32
) (
  input  seq_st_e           st,
  input  logic              is_long,
  input  logic              second,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] pc,
  output logic              req,
  output logic [1:0]        kind,
  output logic [ADDR_W-1:0] addr
);
  localparam logic [ADDR_W-1:0] WORD_OFS = ADDR_W'(2);

  always_comb begin
    req  = 1'b1;
    kind = BK_IDLE;
    addr = '0;
    case (st)
      ST_GAP:        kind = BK_IDLE;
      ST_PRE, ST_PF: begin kind = BK_FETCH; addr = pc; end
      ST_RD:         begin kind = BK_READ;  addr = second ? base + WORD_OFS : base; end
      ST_WR:         begin kind = BK_WRITE; addr = (is_long && !second) ? base + WORD_OFS : base; end
      default:       req = 1'b0;
    endcase
  end
endmodule

// File: rtl/rmw_seq.sv
module rmw_seq import rmw_seq_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 16,
  localparam int OP_W  = 2 * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        ea_mode,
  input  logic [2:0]        ea_reg,
  input  logic [1:0]        op_size,
  input  logic [ADDR_W-1:0] areg_in,
  input  logic [ADDR_W-1:0] ea_in,
  input  logic [ADDR_W-1:0] pc_in,
  output logic              bus_req,
  output logic [1:0]        bus_kind,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [WORD_W-1:0] bus_wdata,
  input  logic              bus_ack,
  input  logic [WORD_W-1:0] bus_rdata,
  output logic              exec_strobe,
  output logic [OP_W-1:0]   operand,
  input  logic [OP_W-1:0]   alu_result,
  output logic              areg_wr,
  output logic [ADDR_W-1:0] areg_out,
  output logic              done,
  output logic              err
);
  localparam logic [ADDR_W-1:0] PC_STEP = ADDR_W'(2);

  plan_t             dec_plan, plan_q;
  seq_st_e           st;
  logic              second;
  logic [1:0]        pre_left;
  logic [ADDR_W-1:0] base, pc_cur, areg_q;
  logic [OP_W-1:0]   wbuf;
  logic              busy, accepted;
  logic [ADDR_W-1:0] dec_step;

  rmw_mode_decode u_dec (.ea_mode(ea_mode), .ea_reg(ea_reg), .op_size(op_size), .plan(dec_plan));

  rmw_bus_map #(.ADDR_W(ADDR_W)) u_map (
    .st(st), .is_long(plan_q.is_long), .second(second), .base(base), .pc(pc_cur),
    .req(bus_req), .kind(bus_kind), .addr(bus_addr)
  );

  assign busy        = (st != ST_IDLE);
  assign accepted    = bus_req && bus_ack;
  assign dec_step    = ADDR_W'(dec_plan.step);
  assign exec_strobe = (st == ST_EXEC);
  assign done        = (st == ST_FIN);
  assign err         = (st == ST_ERR);
  assign areg_wr     = ((st == ST_SETUP) && plan_q.predec) || ((st == ST_FIN) && plan_q.postinc);
  assign areg_out    = plan_q.predec ? areg_q - ADDR_W'(plan_q.step) : areg_q + ADDR_W'(plan_q.step);
  assign bus_wdata   = (plan_q.is_long && second) ? wbuf[OP_W-1:WORD_W] : wbuf[WORD_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      plan_q   <= '0;
      second   <= 1'b0;
      pre_left <= '0;
      base     <= '0;
      pc_cur   <= '0;
      areg_q   <= '0;
      operand  <= '0;
      wbuf     <= '0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          plan_q   <= dec_plan;
          areg_q   <= areg_in;
          pc_cur   <= pc_in;
          operand  <= '0;
          second   <= 1'b0;
          pre_left <= dec_plan.npre;
          if (!dec_plan.use_areg)    base <= ea_in;
          else if (dec_plan.predec)  base <= areg_in - dec_step;
          else                       base <= areg_in;
          st <= dec_plan.valid ? ST_SETUP : ST_ERR;
        end
        ST_SETUP: begin
          if (plan_q.is_dreg)                       st <= ST_EXEC;
          else if (plan_q.predec && plan_q.is_long) st <= ST_GAP;
          else if (pre_left != 2'd0)                st <= ST_PRE;
          else                                      st <= ST_RD;
        end
        ST_GAP: if (accepted) st <= ST_RD;
        ST_PRE: if (accepted) begin
          pc_cur   <= pc_cur + PC_STEP;
          pre_left <= pre_left - 2'd1;
          if (pre_left == 2'd1) st <= ST_RD;
        end
        ST_RD: if (accepted) begin
          if (plan_q.is_long && !second) begin
            operand[OP_W-1:WORD_W] <= bus_rdata;
            second <= 1'b1;
          end else begin
            operand[WORD_W-1:0] <= bus_rdata;
            second <= 1'b0;
            st     <= ST_EXEC;
          end
        end
        ST_EXEC: begin
          wbuf <= alu_result;
          st   <= ST_PF;
        end
        ST_PF: if (accepted) begin
          pc_cur <= pc_cur + PC_STEP;
          st     <= plan_q.is_dreg ? ST_FIN : ST_WR;
        end
        ST_WR: if (accepted) begin
          if (plan_q.is_long && !second) second <= 1'b1;
          else                           st     <= ST_FIN;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rmw_seq_chk.sv
module rmw_seq_chk #(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic [2:0]        ea_mode,
  input logic [2:0]        ea_reg,
  input logic [1:0]        op_size,
  input logic              bus_req,
  input logic              bus_ack,
  input logic [1:0]        bus_kind,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [WORD_W-1:0] bus_wdata,
  input logic              exec_strobe,
  input logic              areg_wr,
  input logic              done,
  input logic              err
);
  logic bad_combo;
  assign bad_combo = (ea_mode == 3'd1) || ((ea_mode == 3'd7) && (ea_reg > 3'd1)) || (op_size == 2'd3);

  a_r9_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_kind) && $stable(bus_addr) && $stable(bus_wdata));

  a_r10_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, err, exec_strobe}));

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r11_bad_gives_err: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && bad_combo |=> err);

  a_r11_err_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !bus_req);

  a_r1_exec_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
    exec_strobe |-> !bus_req);

  a_r5_areg_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
    areg_wr |-> !bus_req);
endmodule

bind rmw_seq rmw_seq_chk #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
  .ea_mode(ea_mode), .ea_reg(ea_reg), .op_size(op_size),
  .bus_req(bus_req), .bus_ack(bus_ack), .bus_kind(bus_kind), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .exec_strobe(exec_strobe), .areg_wr(areg_wr),
  .done(done), .err(err)
);

// File: tb/rmw_seq_test.sv
module rmw_seq_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [2:0]  ea_mode = '0, ea_reg = '0;
  logic [1:0]  op_size = '0;
  logic [31:0] areg_in = '0, ea_in = '0, pc_in = '0;
  logic        bus_req, bus_ack, exec_strobe, areg_wr, done, err;
  logic [1:0]  bus_kind;
  logic [31:0] bus_addr, areg_out, operand, alu_result;
  logic [15:0] bus_wdata, bus_rdata;

  int checks = 0, fails = 0, cyc = 0, stall_n = 0, stall_ctr = 0;
  int ev_k[32], ev_c[32], x_k[32];
  logic [31:0] ev_a[32], ev_d[32], x_a[32], x_d[32];
  int n_ev = 0, n_x = 0;
  bit logging = 0, saw_end = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] rdf(input logic [31:0] a);
    return a[15:0] ^ 16'h5A3C;
  endfunction

  assign bus_rdata  = rdf(bus_addr);
  assign alu_result = ~operand;
  assign bus_ack    = bus_req && (stall_ctr >= stall_n);

  rmw_seq uut (.*);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (bus_req && !bus_ack) stall_ctr <= stall_ctr + 1;
    else stall_ctr <= 0;
  end

  task automatic push(input int k, input logic [31:0] a, input logic [31:0] d);
    if (n_ev < 32) begin ev_k[n_ev] = k; ev_a[n_ev] = a; ev_d[n_ev] = d; ev_c[n_ev] = cyc; n_ev++; end
  endtask

  // event codes: 0..3 bus kinds, 4 exec, 5 areg update, 6 done, 7 err
  always @(negedge clk) if (logging) begin
    if (areg_wr) push(5, areg_out, 0);
    if (bus_req && bus_ack)
      push(int'(bus_kind), bus_addr, bus_kind == 2'd1 ? {16'h0, bus_rdata} :
                                     bus_kind == 2'd2 ? {16'h0, bus_wdata} : 32'h0);
    if (exec_strobe) push(4, 0, operand);
    if (done) begin push(6, 0, 0); saw_end = 1; end
    if (err)  begin push(7, 0, 0); saw_end = 1; end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic ex(input int k, input logic [31:0] a, input logic [31:0] d);
    x_k[n_x] = k; x_a[n_x] = a; x_d[n_x] = d; n_x++;
  endtask

  // Expected event list written from the requirements
  task automatic build(input logic [2:0] m, input logic [2:0] r, input logic [1:0] s,
                       input logic [31:0] ar, input logic [31:0] ea, input logic [31:0] pc);
    logic [31:0] step, base, op, res, p;
    int np;
    bit lng, ok;
    n_x  = 0;
    step = (s == 0) ? 1 : (s == 1) ? 2 : 4;
    lng  = (s == 2);
    ok   = (s != 3) && (m != 1) && !(m == 7 && r > 1);
    if (!ok) begin ex(7, 0, 0); return; end
    if (m == 0) begin ex(4, 0, 0); ex(0, pc, 0); ex(6, 0, 0); return; end
    base = (m == 2 || m == 3) ? ar : (m == 4) ? ar - step : ea;
    np   = (m == 5 || m == 6 || (m == 7 && r == 0)) ? 1 : (m == 7 && r == 1) ? 2 : 0;
    p    = pc;
    if (m == 4) begin ex(5, base, 0); if (lng) ex(3, 0, 0); end
    for (int i = 0; i < np; i++) begin ex(0, p, 0); p = p + 2; end
    ex(1, base, {16'h0, rdf(base)});
    if (lng) ex(1, base + 2, {16'h0, rdf(base + 2)});
    op  = lng ? {rdf(base), rdf(base + 2)} : {16'h0, rdf(base)};
    res = ~op;
    ex(4, 0, op);
    ex(0, p, 0);
    if (lng) begin ex(2, base + 2, {16'h0, res[15:0]}); ex(2, base, {16'h0, res[31:16]}); end
    else ex(2, base, {16'h0, res[15:0]});
    if (m == 3) ex(5, ar + step, 0);
    ex(6, 0, 0);
  endtask

  task automatic run_case(input string tag, input logic [2:0] m, input logic [2:0] r,
                          input logic [1:0] s, input logic [31:0] ar, input logic [31:0] ea,
                          input logic [31:0] pc, input int stall, input bit poke);
    int t0, last_bus;
    build(m, r, s, ar, ea, pc);
    stall_n = stall;
    @(negedge clk);
    n_ev = 0; saw_end = 0; logging = 1;
    ea_mode = m; ea_reg = r; op_size = s; areg_in = ar; ea_in = ea; pc_in = pc; start = 1;
    t0 = cyc;
    @(negedge clk);
    start = 0;
    if (poke) begin
      repeat (2) @(negedge clk);
      ea_mode = 3'd1; start = 1;
      @(negedge clk);
      start = 0;
    end
    for (int w = 0; w < 300 && !saw_end; w++) @(negedge clk);
    if (!saw_end) begin
      checks++; fails++;
      $display("FAIL %s: watchdog, actual no end, expected done or err", tag);
    end
    repeat (4) @(negedge clk);
    logging = 0;
    chk({tag, " event count"}, n_ev, n_x);
    for (int i = 0; i < n_x && i < n_ev; i++) begin
      chk({tag, " kind"}, ev_k[i], x_k[i]);
      chk({tag, " addr"}, ev_a[i], x_a[i]);
      chk({tag, " data"}, ev_d[i], x_d[i]);
    end
    if (stall == 0 && n_ev > 0 && n_ev == n_x) begin
      if (ev_k[n_ev-1] == 7) chk({tag, " R11 err timing"}, ev_c[n_ev-1], t0 + 1);
      else begin
        last_bus = 0;
        for (int i = 0; i < n_ev; i++) if (ev_k[i] < 4) last_bus = ev_c[i];
        chk({tag, " R10 done timing"}, ev_c[n_ev-1], last_bus + 1);
        if (m == 4) chk({tag, " R6 predec timing"}, ev_c[0], t0 + 1);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R10 reset req", bus_req, 0);
    chk("R10 reset done", done, 0);
    chk("R10 reset err", err, 0);
    chk("R10 reset exec", exec_strobe, 0);
    run_case("R1 dreg word",        3'd0, 3'd3, 2'd1, 32'h100, 32'h0,    32'h4000, 0, 0);
    run_case("R2 ind byte",         3'd2, 3'd0, 2'd0, 32'h1230, 32'h0,   32'h4000, 0, 0);
    run_case("R2 ind word",         3'd2, 3'd1, 2'd1, 32'h2000, 32'h0,   32'h4100, 0, 0);
    run_case("R3 R4 ind long",      3'd2, 3'd2, 2'd2, 32'h3000, 32'h0,   32'h4200, 0, 0);
    run_case("R5 postinc byte",     3'd3, 3'd0, 2'd0, 32'h5001, 32'h0,   32'h4300, 0, 0);
    run_case("R5 postinc long",     3'd3, 3'd0, 2'd2, 32'h5100, 32'h0,   32'h4300, 0, 0);
    run_case("R6 predec word",      3'd4, 3'd0, 2'd1, 32'h6002, 32'h0,   32'h4400, 0, 0);
    run_case("R6 predec long",      3'd4, 3'd5, 2'd2, 32'h6100, 32'h0,   32'h4400, 0, 0);
    run_case("R7 disp word",        3'd5, 3'd0, 2'd1, 32'h0,  32'h7010,  32'h4500, 0, 0);
    run_case("R7 index long",       3'd6, 3'd0, 2'd2, 32'h0,  32'h7100,  32'h4500, 0, 0);
    run_case("R7 absw byte",        3'd7, 3'd0, 2'd0, 32'h0,  32'h7203,  32'h4600, 0, 0);
    run_case("R8 R13 absl long",    3'd7, 3'd1, 2'd2, 32'h0,  32'h8000,  32'h4700, 0, 0);
    run_case("R9 stall predec long",3'd4, 3'd0, 2'd2, 32'h9008, 32'h0,   32'h4800, 2, 0);
    run_case("R9 stall absl word",  3'd7, 3'd1, 2'd1, 32'h0,  32'h9100,  32'h4900, 1, 0);
    run_case("R11 areg direct",     3'd1, 3'd0, 2'd1, 32'h0,  32'h0,     32'h0,    0, 0);
    run_case("R11 mode7 sel4",      3'd7, 3'd4, 2'd1, 32'h0,  32'h0,     32'h0,    0, 0);
    run_case("R11 size3",           3'd2, 3'd0, 2'd3, 32'h10, 32'h0,     32'h0,    0, 0);
    run_case("R12 start while busy",3'd2, 3'd0, 2'd2, 32'hA000, 32'h0,   32'h4A00, 1, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule